// File: doc/BRIEF.md
# Command-Dispatched Serial Register Port

This block is the device side of a synchronous serial link for a measurement converter. A host drives a serial clock, a data line into the device and an active-low select. The device answers on a return data line with a separate output enable. Every exchange opens with one command byte. The command names a register and an operation: a write, a single read, or a streaming read of the conversion result. The length of the data phase that follows comes from the register chosen, and can be 8, 16 or 24 bits. Bits travel most significant first.

The serial inputs are sampled with the block's own clock through synchronisers. A polarity input sets the idle level of the serial clock. The edge leaving idle launches return data and the edge returning to idle samples incoming data.

Conversion results arrive on a valid/ready input. A result is taken in any cycle where `res_valid` and `res_ready` are both high. `res_ready` stays low from the moment a readout of the result word starts until its last bit has been sampled, so a word is never replaced while it is being shifted out. The producer must hold `res_valid` and `res_data` until it sees the transfer. Taking a result pulls `rdy_n` low. A complete 24-bit readout of the result sets `rdy_n` high again.

Top module: `serial_cmd_port`

## Requirements
- R1: After reset `rdy_n`=1, `res_ready`=1, `dout_oe`=0, `mode_q`=0x01B0, `filter_q`=0x200000 and `dac_q`=0x00, and the port waits for a command byte.
- R2: Command byte bits [3:0] are the address and bits [5:4] the operation: 00 write, 01 single read, 10 streaming read, 11 stop. A command does nothing beyond its own 8 bits when any of these holds: bits [7:6] are nonzero, the address is 12 or above, it is a write to address 0 (status) or 1 (result), or it is a streaming read of any address other than 1.
- R3: A write to mode (address 2, 16 bits), filter (address 3, 24 bits) or DAC (address 4, 8 bits) takes exactly that many bits, MSB first. The data phase starts on the bit right after the command, so command and data may form one burst. The port then waits for a command again.
- R4: An all-ones byte clocked in after a completed write is decoded as a command that does nothing, and it leaves every register unchanged.
- R5: A single read (0x10 | address) shifts the addressed register out MSB first over its own length, with `dout_oe` high for the whole data phase.
- R6: The port is half duplex. `dout_oe` is low during command bytes and write data phases.
- R7: While a readout of the result word is in progress, `res_ready` is low and the held result does not change. Taking a result pulls `rdy_n` low, and a full 24-bit readout of address 1 sets it high again.
- R8: Command 0x21 enters streaming read. From then on, every 24 serial clocks shift out the current result, MSB first, and each completed word sets `rdy_n` high.
- R9: During streaming read, DIN is gathered into bytes aligned to the word start. A byte equal to 0x30 ends streaming read and the port then waits for a command. A 0x30 pattern that is not aligned to a byte has no effect.
- R10: With `pol`=0 the serial clock idles low, and with `pol`=1 it idles high. Writes and reads behave the same under both settings.
- R11: Raising `cs_n` discards a partial byte, clears the bit count, ends a pending write or single read, and forces `dout_oe` low. A streaming read stays active across deselection.
- R12: After 32 consecutive ones are sampled on DIN, the port waits for a command, including when it was in streaming read. Further ones are ignored until a zero, which counts as the first command bit.
- R13: A single read of address 0 returns 8 bits, with bit 7 equal to `rdy_n` and bits 6:0 zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, samples all serial inputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low select |
| din | input | 1 | Serial data into the device |
| pol | input | 1 | Serial clock idle level |
| dout | output | 1 | Serial data out of the device |
| dout_oe | output | 1 | High while dout carries data; pad is released otherwise |
| res_valid | input | 1 | Conversion result offered |
| res_ready | output | 1 | Result can be taken this cycle |
| res_data | input | 24 | Conversion result word |
| rdy_n | output | 1 | Low while an unread result is held |
| mode_q | output | 16 | Mode register contents |
| filter_q | output | 24 | Filter register contents |
| dac_q | output | 8 | DAC register contents |

## Verification
Three kinds of write are tried: a command and data sent as one 16-bit burst, separate bytes, and a 24-bit write followed by ones. Together they show whether the data length follows the chosen register and whether trailing ones are dropped. Reads of 8, 16 and 24 bits and a status read check alignment and the enable. Streaming read runs with a zero DIN pattern and with one that holds an unaligned 0x30, then ends with an aligned 0x30, which separates byte-aligned exit detection from a sliding match. Illegal commands, a partial byte cut off by deselection, a run of 40 ones and inverted clock polarity are each followed by a DAC write, so any loss of byte alignment shows up at `dac_q`.

// File: rtl/scp_pkg.sv
package scp_pkg;
  localparam int DW       = 24;
  localparam int AW       = 4;
  localparam int NREG     = 12;
  localparam int CMD_BITS = 8;
  localparam int LW       = $clog2(DW + 1);

  localparam logic [AW-1:0] ADR_STAT = 4'd0;
  localparam logic [AW-1:0] ADR_DATA = 4'd1;
  localparam logic [AW-1:0] ADR_MODE = 4'd2;
  localparam logic [AW-1:0] ADR_FILT = 4'd3;
  localparam logic [AW-1:0] ADR_DAC  = 4'd4;
  localparam logic [AW-1:0] ADR_LAST = AW'(NREG - 1);
  localparam logic [7:0]    STOP_BYTE = 8'h30;

  typedef enum logic [1:0] {ST_CMD, ST_WR, ST_RD, ST_CRD} port_st_t;
  typedef enum logic [1:0] {OP_WRITE, OP_READ, OP_STREAM, OP_STOP} op_t;

  function automatic logic [LW-1:0] reg_len(input logic [AW-1:0] a);
    case (a)
      4'd0, 4'd4, 4'd8, 4'd9, 4'd10, 4'd11: reg_len = LW'(8);
      4'd2:                                 reg_len = LW'(16);
      4'd1, 4'd3, 4'd5, 4'd6, 4'd7:         reg_len = LW'(24);
      default:                              reg_len = '0;
    endcase
  endfunction

  function automatic logic reg_writable(input logic [AW-1:0] a);
    reg_writable = (a >= ADR_MODE) && (a <= ADR_LAST);
  endfunction

  function automatic logic [DW-1:0] reg_init(input int a);
    case (a)
      2:       reg_init = 24'h0001B0;
      3:       reg_init = 24'h200000;
      5:       reg_init = 24'h800000;
      6:       reg_init = 24'h590000;
      default: reg_init = '0;
    endcase
  endfunction
endpackage

// File: rtl/scp_edge.sv
module scp_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic din,
  input  logic pol,
  output logic lead,
  output logic trail,
  output logic sel,
  output logic din_s
);
  logic [STAGES-1:0] s_clk, s_cs, s_din;
  logic norm, prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_clk <= '0;
      s_cs  <= '1;
      s_din <= '0;
      prev  <= 1'b0;
    end else begin
      s_clk <= {s_clk[STAGES-2:0], sclk};
      s_cs  <= {s_cs[STAGES-2:0], cs_n};
      s_din <= {s_din[STAGES-2:0], din};
      prev  <= norm;
    end
  end

  // normalised clock: 0 is idle whatever the polarity
  assign norm  = s_clk[STAGES-1] ^ pol;
  assign sel   = !s_cs[STAGES-1];
  assign din_s = s_din[STAGES-1];
  assign lead  = sel && norm && !prev;
  assign trail = sel && !norm && prev;
endmodule

// File: rtl/scp_ctrl.sv
module scp_ctrl
  import scp_pkg::*;
#(
  parameter int RESET_ONES = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lead,
  input  logic          trail,
  input  logic          sel,
  input  logic          din_s,
  input  logic [DW-1:0] rd_val,
  input  logic [DW-1:0] data_word,
  output logic [AW-1:0] rd_addr,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          data_done,
  output logic          data_busy,
  output logic          dout,
  output logic          dout_oe
);
  localparam int OW = $clog2(RESET_ONES + 1);
  localparam logic [OW-1:0] ONES_MAX = OW'(RESET_ONES);

  port_st_t       st;
  logic [LW-1:0]  bitcnt, cnt_n, len;
  logic [DW-1:0]  sr, tx, shifted;
  logic [AW-1:0]  addr_q, cmd_addr;
  logic [OW-1:0]  ones_q;
  logic           dout_q, busy_q;
  logic [7:0]     cmd;
  op_t            cmd_op;
  logic           cmd_legal, ones_reset, byte_edge;

  assign shifted    = {sr[DW-2:0], din_s};
  assign cnt_n      = bitcnt + 1'b1;
  assign cmd        = shifted[7:0];
  assign cmd_op     = op_t'(cmd[5:4]);
  assign cmd_addr   = cmd[AW-1:0];
  assign cmd_legal  = (cmd[7:6] == 2'b00) && (cmd_addr <= ADR_LAST);
  assign ones_reset = sel && trail && din_s && (ones_q >= ONES_MAX - 1'b1);
  assign byte_edge  = (cnt_n[2:0] == 3'b000);

  assign rd_addr   = cmd_addr;
  assign wr_addr   = addr_q;
  assign wr_data   = shifted;
  assign wr_en     = trail && !ones_reset && (st == ST_WR) && (cnt_n == len);
  assign data_done = trail && !ones_reset &&
                     (((st == ST_RD) && (addr_q == ADR_DATA) && (cnt_n == len)) ||
                      ((st == ST_CRD) && (cnt_n == LW'(DW))));
  assign data_busy = busy_q;
  assign dout      = dout_q;
  assign dout_oe   = sel && ((st == ST_RD) || (st == ST_CRD));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_CMD;
      bitcnt <= '0;
      len    <= LW'(CMD_BITS);
      sr     <= '0;
      tx     <= '0;
      addr_q <= '0;
      ones_q <= '0;
      dout_q <= 1'b0;
      busy_q <= 1'b0;
    end else if (!sel) begin
      bitcnt <= '0;
      ones_q <= '0;
      busy_q <= 1'b0;
      if (st != ST_CRD) st <= ST_CMD;
    end else begin
      if (lead && ((st == ST_RD) || (st == ST_CRD))) begin
        if ((st == ST_CRD) && (bitcnt == '0)) begin
          dout_q <= data_word[DW-1];
          tx     <= {data_word[DW-2:0], 1'b0};
          busy_q <= 1'b1;
        end else begin
          dout_q <= tx[DW-1];
          tx     <= {tx[DW-2:0], 1'b0};
        end
      end
      if (trail) begin
        sr <= shifted;
        if (!din_s)                 ones_q <= '0;
        else if (ones_q != ONES_MAX) ones_q <= ones_q + 1'b1;
        if (ones_reset) begin
          st     <= ST_CMD;
          bitcnt <= '0;
          busy_q <= 1'b0;
        end else begin
          case (st)
            ST_CMD: begin
              if (cnt_n == LW'(CMD_BITS)) begin
                bitcnt <= '0;
                case (cmd_op)
                  OP_WRITE: if (cmd_legal && reg_writable(cmd_addr)) begin
                    st     <= ST_WR;
                    len    <= reg_len(cmd_addr);
                    addr_q <= cmd_addr;
                  end
                  OP_READ: if (cmd_legal) begin
                    st     <= ST_RD;
                    len    <= reg_len(cmd_addr);
                    addr_q <= cmd_addr;
                    tx     <= rd_val << (LW'(DW) - reg_len(cmd_addr));
                    busy_q <= (cmd_addr == ADR_DATA);
                  end
                  OP_STREAM: if (cmd_legal && (cmd_addr == ADR_DATA)) begin
                    st     <= ST_CRD;
                    addr_q <= cmd_addr;
                  end
                  OP_STOP: ;
                endcase
              end else begin
                bitcnt <= cnt_n;
              end
            end
            ST_WR: begin
              if (cnt_n == len) begin
                st     <= ST_CMD;
                bitcnt <= '0;
              end else begin
                bitcnt <= cnt_n;
              end
            end
            ST_RD: begin
              if (cnt_n == len) begin
                st     <= ST_CMD;
                bitcnt <= '0;
                busy_q <= 1'b0;
              end else begin
                bitcnt <= cnt_n;
              end
            end
            ST_CRD: begin
              if (byte_edge && (shifted[7:0] == STOP_BYTE)) begin
                st     <= ST_CMD;
                bitcnt <= '0;
                busy_q <= 1'b0;
              end else if (cnt_n == LW'(DW)) begin
                bitcnt <= '0;
                busy_q <= 1'b0;
              end else begin
                bitcnt <= cnt_n;
              end
            end
          endcase
        end
      end
    end
  end

  // R3: only writable registers are ever written, and only from a write phase
  a_r3_write_target: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (reg_writable(wr_addr) && (st == ST_WR)));
  // R11: deselection leaves the bit count at zero and no readout pending
  a_r11_deselect_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> ((bitcnt == '0) && !busy_q));
  // R9: leaving the streaming read always lands in the command state
  a_r9_leave_stream: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(st) == ST_CRD) && (st != ST_CRD)) |-> (st == ST_CMD));
  // R12: the ones counter saturates at its limit
  a_r12_ones_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    ones_q <= ONES_MAX);
  // R7: a result readout is only flagged while a read phase is active
  a_r7_busy_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> ((st == ST_RD) || (st == ST_CRD)));
endmodule

// File: rtl/scp_regs.sv
module scp_regs
  import scp_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_val,
  input  logic          res_valid,
  input  logic [DW-1:0] res_data,
  input  logic          data_busy,
  input  logic          data_done,
  output logic [DW-1:0] data_word,
  output logic          rdy_n,
  output logic [15:0]   mode_q,
  output logic [DW-1:0] filter_q,
  output logic [7:0]    dac_q
);
  localparam int NSLOT = 2 ** AW;

  logic [DW-1:0] rv [NSLOT];
  logic [DW-1:0] data_q;
  logic          rdy_n_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      rdy_n_q <= 1'b1;
    end else if (res_valid && !data_busy) begin
      data_q  <= res_data;
      rdy_n_q <= 1'b0;
    end else if (data_done) begin
      rdy_n_q <= 1'b1;
    end
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    if (g == 0) begin : g_status
      assign rv[g] = {{(DW-8){1'b0}}, rdy_n_q, 7'b0};
    end else if (g == 1) begin : g_result
      assign rv[g] = data_q;
    end else if (g < NREG) begin : g_store
      localparam int W = int'(reg_len(AW'(g)));
      localparam logic [DW-1:0] INIT = reg_init(g);
      logic [W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             q <= INIT[W-1:0];
        else if (wr_en && (wr_addr == AW'(g)))  q <= wr_data[W-1:0];
      end
      assign rv[g] = DW'(q);
    end else begin : g_empty
      assign rv[g] = '0;
    end
  end

  assign rd_val    = rv[rd_addr];
  assign data_word = data_q;
  assign rdy_n     = rdy_n_q;
  assign mode_q    = rv[ADR_MODE][15:0];
  assign filter_q  = rv[ADR_FILT];
  assign dac_q     = rv[ADR_DAC][7:0];

  // R7: the held result is frozen while it is being shifted out
  a_r7_frozen_while_read: assert property (@(posedge clk) disable iff (!rst_n)
    (data_busy && $past(data_busy)) |-> $stable(data_q));
  // R7: an accepted result flags itself as unread
  a_r7_accept_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !data_busy) |=> !rdy_n);
endmodule

// File: rtl/serial_cmd_port.sv
module serial_cmd_port
  import scp_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RESET_ONES  = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk,
  input  logic          cs_n,
  input  logic          din,
  input  logic          pol,
  output logic          dout,
  output logic          dout_oe,
  input  logic          res_valid,
  output logic          res_ready,
  input  logic [DW-1:0] res_data,
  output logic          rdy_n,
  output logic [15:0]   mode_q,
  output logic [DW-1:0] filter_q,
  output logic [7:0]    dac_q
);
  logic          lead, trail, sel, din_s;
  logic [DW-1:0] rd_val, data_word, wr_data;
  logic [AW-1:0] rd_addr, wr_addr;
  logic          wr_en, data_done, data_busy;

  scp_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .din(din), .pol(pol),
    .lead(lead), .trail(trail), .sel(sel), .din_s(din_s)
  );

  scp_ctrl #(.RESET_ONES(RESET_ONES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .lead(lead), .trail(trail), .sel(sel), .din_s(din_s),
    .rd_val(rd_val), .data_word(data_word), .rd_addr(rd_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .data_done(data_done), .data_busy(data_busy), .dout(dout), .dout_oe(dout_oe)
  );

  scp_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_val(rd_val), .res_valid(res_valid), .res_data(res_data),
    .data_busy(data_busy), .data_done(data_done), .data_word(data_word),
    .rdy_n(rdy_n), .mode_q(mode_q), .filter_q(filter_q), .dac_q(dac_q)
  );

  assign res_ready = !data_busy;
endmodule

// File: tb/serial_cmd_port_bench.sv
`timescale 1ns/1ps
module serial_cmd_port_bench;
  localparam int H = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, din = 1'b0, pol = 1'b0;
  logic dout, dout_oe, res_valid = 1'b0, res_ready, rdy_n;
  logic [23:0] res_data = '0;
  logic [15:0] mode_q;
  logic [23:0] filter_q;
  logic [7:0]  dac_q;

  int checks = 0, errors = 0, hi_cnt = 0;
  bit done = 0;
  logic [31:0] rd;
  logic any_oe, all_oe;
  logic [7:0]  m_dac;
  logic [15:0] m_mode;
  logic [23:0] m_filter;
  logic [23:0] results [$];

  always #10 clk = ~clk;

  serial_cmd_port u_serial_cmd_port (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .din(din), .pol(pol),
    .dout(dout), .dout_oe(dout_oe), .res_valid(res_valid), .res_ready(res_ready),
    .res_data(res_data), .rdy_n(rdy_n), .mode_q(mode_q), .filter_q(filter_q),
    .dac_q(dac_q)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // R6/R11: pad released whenever select has been high for a few cycles
  always @(negedge clk) begin
    hi_cnt = cs_n ? hi_cnt + 1 : 0;
    if (rst_n && hi_cnt >= 4) chk("R11 oe low while deselected", 32'(dout_oe), 0);
  end

  task automatic xfer(input int n, input logic [31:0] w, output logic [31:0] r,
                      output logic a_oe, output logic l_oe);
    r = '0; a_oe = 1'b0; l_oe = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sclk = ~pol;
      din  = w[n-1-i];
      repeat (H - 1) @(negedge clk);
      r = {r[30:0], dout};
      a_oe = a_oe | dout_oe;
      l_oe = l_oe & dout_oe;
      @(negedge clk);
      sclk = pol;
      repeat (H - 1) @(negedge clk);
    end
  endtask

  task automatic select();
    @(negedge clk); cs_n = 1'b0; repeat (4) @(negedge clk);
  endtask
  task automatic deselect();
    @(negedge clk); cs_n = 1'b1; repeat (6) @(negedge clk);
  endtask

  task automatic push(input logic [23:0] v);
    @(negedge clk);
    while (!res_ready) @(negedge clk);
    res_data = v; res_valid = 1'b1;
    results.push_back(v);
    @(negedge clk);
    res_valid = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic cfg_check(input string tag);
    chk({tag, " dac"}, 32'(dac_q), 32'(m_dac));
    chk({tag, " mode"}, 32'(mode_q), 32'(m_mode));
    chk({tag, " filter"}, 32'(filter_q), 32'(m_filter));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] hi;
    logic [23:0] exp;
    m_dac = 8'h00; m_mode = 16'h01B0; m_filter = 24'h200000;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    chk("R1 rdy_n", 32'(rdy_n), 1);
    chk("R1 res_ready", 32'(res_ready), 1);
    chk("R1 dout_oe", 32'(dout_oe), 0);
    cfg_check("R1");

    select();
    // R3 command and 8-bit data as one burst; R6 no output during write
    xfer(16, 32'h0423, rd, any_oe, all_oe); m_dac = 8'h23;
    chk("R6 oe during write", 32'(any_oe), 0);
    xfer(8, 32'h02, rd, any_oe, all_oe);
    xfer(16, 32'hB180, rd, any_oe, all_oe); m_mode = 16'hB180;
    cfg_check("R3 writes");
    // R4 ones after a 24-bit write
    xfer(8, 32'h03, rd, any_oe, all_oe);
    xfer(32, 32'h800010FF, rd, any_oe, all_oe); m_filter = 24'h800010;
    xfer(16, 32'h0411, rd, any_oe, all_oe); m_dac = 8'h11;
    cfg_check("R4 trailing ones");

    // R5 single reads of each length
    xfer(8, 32'h12, rd, any_oe, all_oe);
    xfer(16, 32'h0, rd, any_oe, all_oe);
    chk("R5 read mode", rd, 32'(m_mode));
    chk("R5 oe during read", 32'(all_oe), 1);
    xfer(8, 32'h14, rd, any_oe, all_oe);
    xfer(8, 32'h0, rd, any_oe, all_oe);
    chk("R5 read dac", rd, 32'(m_dac));
    xfer(8, 32'h13, rd, any_oe, all_oe);
    xfer(24, 32'h0, rd, any_oe, all_oe);
    chk("R5 read filter", rd, 32'(m_filter));
    // R13 status with no result held
    xfer(8, 32'h10, rd, any_oe, all_oe);
    xfer(8, 32'h0, rd, any_oe, all_oe);
    chk("R13 status idle", rd, 32'h80);

    // R7 result handshake and single readout
    push(24'hA5C3E1);
    chk("R7 rdy_n after accept", 32'(rdy_n), 0);
    xfer(8, 32'h10, rd, any_oe, all_oe);
    xfer(8, 32'h0, rd, any_oe, all_oe);
    chk("R13 status pending", rd, 32'h00);
    xfer(8, 32'h11, rd, any_oe, all_oe);
    xfer(4, 32'h0, hi, any_oe, all_oe);
    chk("R7 ready low mid readout", 32'(res_ready), 0);
    xfer(20, 32'h0, rd, any_oe, all_oe);
    exp = results.pop_front();
    chk("R7 result value", {8'h0, hi[3:0], rd[19:0]}, 32'(exp));
    chk("R7 rdy_n after readout", 32'(rdy_n), 1);
    chk("R7 ready after readout", 32'(res_ready), 1);

    // R8 streaming read
    xfer(8, 32'h21, rd, any_oe, all_oe);
    push(24'h123456);
    xfer(24, 32'h0, rd, any_oe, all_oe);
    exp = results.pop_front();
    chk("R8 word 1", rd, 32'(exp));
    chk("R8 rdy_n word 1", 32'(rdy_n), 1);
    push(24'hFEDCBA);
    // R9 unaligned 0x30 on DIN must not end the stream
    xfer(24, 32'h030000, rd, any_oe, all_oe);
    exp = results.pop_front();
    chk("R8 word 2", rd, 32'(exp));
    push(24'h0F0F0F);
    xfer(24, 32'h0, rd, any_oe, all_oe);
    exp = results.pop_front();
    chk("R9 still streaming", rd, 32'(exp));
    xfer(8, 32'h30, rd, any_oe, all_oe);
    xfer(16, 32'h0466, rd, any_oe, all_oe); m_dac = 8'h66;
    repeat (4) @(negedge clk);
    chk("R9 exit then write", 32'(dac_q), 32'(m_dac));
    chk("R9 oe after exit", 32'(dout_oe), 0);

    // R2 no-op commands
    xfer(8, 32'h0E, rd, any_oe, all_oe);
    xfer(16, 32'h0477, rd, any_oe, all_oe); m_dac = 8'h77;
    chk("R2 bad address", 32'(dac_q), 32'(m_dac));
    xfer(8, 32'h01, rd, any_oe, all_oe);
    xfer(16, 32'h0478, rd, any_oe, all_oe); m_dac = 8'h78;
    chk("R2 write to result", 32'(dac_q), 32'(m_dac));
    xfer(16, 32'hC43F, rd, any_oe, all_oe);
    xfer(16, 32'h0479, rd, any_oe, all_oe); m_dac = 8'h79;
    chk("R2 high bits set", 32'(dac_q), 32'(m_dac));
    xfer(8, 32'h22, rd, any_oe, all_oe);
    xfer(16, 32'h0412, rd, any_oe, all_oe); m_dac = 8'h12;
    chk("R2 stream of non-result", 32'(dac_q), 32'(m_dac));

    // R11 partial byte discarded by deselection
    xfer(4, 32'h0, rd, any_oe, all_oe);
    deselect();
    select();
    xfer(16, 32'h045A, rd, any_oe, all_oe); m_dac = 8'h5A;
    chk("R11 realign after deselect", 32'(dac_q), 32'(m_dac));

    // R12 long run of ones leaves streaming read
    xfer(8, 32'h21, rd, any_oe, all_oe);
    xfer(32, 32'hFFFFFFFF, rd, any_oe, all_oe);
    xfer(8, 32'hFF, rd, any_oe, all_oe);
    xfer(16, 32'h043C, rd, any_oe, all_oe); m_dac = 8'h3C;
    chk("R12 ones reset", 32'(dac_q), 32'(m_dac));
    cfg_check("R12");

    // R10 inverted clock polarity
    deselect();
    @(negedge clk); pol = 1'b1; sclk = 1'b1;
    repeat (6) @(negedge clk);
    select();
    xfer(16, 32'h04C7, rd, any_oe, all_oe); m_dac = 8'hC7;
    chk("R10 write pol=1", 32'(dac_q), 32'(m_dac));
    xfer(8, 32'h12, rd, any_oe, all_oe);
    xfer(16, 32'h0, rd, any_oe, all_oe);
    chk("R10 read pol=1", rd, 32'(m_mode));
    deselect();
    cfg_check("R10");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule